// File: doc/BRIEF.md
# Real-Mode Far Return Sequencer

This block performs the stack side of a far return while the processor runs in real addressing mode (or in virtual-8086 mode). After a one-cycle `start` strobe, it reads the return instruction pointer and then the return code-segment selector from the stack. The reads go one at a time over a valid/ready request port, and each is answered by a single-cycle response that may carry an abort. It then produces the new instruction pointer, the new selector, the updated stack pointer and a cycle-cost figure, and pulses `done`.

Operand size (16 or 32 bits), stack-pointer size (16-bit SP within the low half, or the full 32-bit ESP) and an optional 16-bit release count are captured at `start`. The block keeps the instruction pointer current at `start`, so a return that faults can be restarted. When protection is enabled and virtual-8086 mode is off, the block does no stack access at all. It instead raises a handoff request towards an external protected-mode handler and waits for that handler to acknowledge.

Top module: `farRetSeq`

## Requirements
- R1: With `protEnable`=1 and `v86Mode`=0 at `start`, no memory request is issued. `pmReqValid` rises and stays high until `pmReqReady`, with `pmReqOpSize32` and `pmReqImm` equal to the captured operand size and release count. One cycle after the acknowledge, `done` pulses with `aborted`=0 and `cycleCost`=0, and `newIp`, `newCs` and `newSp` keep their earlier values.
- R2: With 16-bit operands (`opSize32`=0), reads are narrow (`memWide`=0). `newIp` is the low 16 bits of the data read at the stack top, zero-extended, and `newCs` is the low 16 bits of the data read at stack top + 2.
- R3: With 32-bit operands, reads are wide (`memWide`=1). `newIp` is the full 32-bit data read at the stack top, and `newCs` is the low 16 bits of the data read at stack top + 4.
- R4: On a successful return, the stack pointer advances by 4 plus the release count for 16-bit operands, and by 8 plus the release count for 32-bit operands.
- R5: With `useImm`=0 the release count is zero, whatever value `immCount` holds. This is also seen on `pmReqImm`.
- R6: If a response carries `memRspAbort`=1, no further read is issued. `done` pulses with `aborted`=1 and `cycleCost`=0, `newSp` equals the stack pointer captured at `start`, `newIp` equals the captured previous instruction pointer, and `newCs` is unchanged.
- R7: With `stackSize32`=1 the base address is the full `curSp` and the full 32-bit sum is written back. With `stackSize32`=0 only the low 16 bits are used: addresses wrap modulo 2^16 with the upper 16 address bits zero, and `newSp` keeps the upper 16 bits of the captured pointer.
- R8: On a successful return, `cycleCost` is 13 when `laterModel`=1 and 18 when `laterModel`=0.
- R9: Reads are strictly sequential. The instruction-pointer read comes first and the selector read second, each request is issued only after the previous response, and `memReqValid` and `memAddr` hold steady until `memReqReady`.
- R10: `done` is a one-cycle pulse in the cycle after the final response or acknowledge. The results are valid with it and stay held until the next completion.
- R11: `savedIp` equals `curIp` as sampled at `start`.
- R12: `start` and all other operation inputs are ignored while an operation is in progress. The inputs are captured only at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a far return (sampled when idle) |
| opSize32 | input | 1 | 1 = 32-bit operand size |
| stackSize32 | input | 1 | 1 = use full ESP, 0 = low 16-bit SP |
| useImm | input | 1 | 1 = immediate release count present |
| immCount | input | 16 | Extra stack bytes to release |
| protEnable | input | 1 | Protection-enable state |
| v86Mode | input | 1 | Virtual-8086 flag |
| laterModel | input | 1 | 1 = later CPU model cost table |
| curIp | input | 32 | Instruction pointer at start |
| curSp | input | 32 | Stack pointer at start |
| memReqValid | output | 1 | Stack read request |
| memReqReady | input | 1 | Read request accepted |
| memAddr | output | 32 | Stack read offset |
| memWide | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 32 | Read response data |
| memRspAbort | input | 1 | Read faulted |
| pmReqValid | output | 1 | Protected-mode handoff request |
| pmReqReady | input | 1 | Handoff acknowledge |
| pmReqOpSize32 | output | 1 | Operand size passed with handoff |
| pmReqImm | output | 16 | Release count passed with handoff |
| newIp | output | 32 | Returned instruction pointer |
| newCs | output | 16 | Returned code selector |
| newSp | output | 32 | Updated stack pointer |
| cycleCost | output | 5 | Cycle cost of the completed return |
| savedIp | output | 32 | Instruction pointer captured at start |
| done | output | 1 | Completion pulse |
| aborted | output | 1 | Completion was an abort |

## Verification
Assertions check several properties on every cycle. The memory and handoff ports are never requested together, and a pending read or handoff keeps its request and payload steady until accepted. `done` never lasts two cycles, an abort completion always carries zero cost, any nonzero cost is one of the two model values, and narrow-stack addresses never set upper bits. The data-dependent properties can only be shown by the bench scenarios. These are the selection of IP and selector from the response words, the 16-bit address and pointer wrap, the ignored release count, the ordering and count of reads, restoring the pointer after an abort at either read, and ignoring `start` while busy. The bench compares each of these against its own model of the stack contents.

// File: rtl/farRetPkg.sv
`timescale 1ns/1ps
package farRetPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PM_REQ,
    ST_IP_REQ,
    ST_IP_WAIT,
    ST_CS_REQ,
    ST_CS_WAIT
  } seqState_t;

  typedef struct packed {
    logic latchIn;
    logic selCsAddr;
    logic captureIp;
    logic commitOk;
    logic commitAbort;
    logic commitPm;
  } ctrlStrobes_t;

endpackage

// File: rtl/farRetCtrl.sv
`timescale 1ns/1ps
module farRetCtrl
  import farRetPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         protEnable,
  input  logic         v86Mode,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         memRspAbort,
  input  logic         pmReqReady,
  output logic         memReqValid,
  output logic         pmReqValid,
  output ctrlStrobes_t strobes
);

  seqState_t state;
  seqState_t stateNext;
  logic      protPath;

  assign protPath = protEnable & ~v86Mode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.latchIn = 1'b1;
          stateNext = protPath ? ST_PM_REQ : ST_IP_REQ;
        end
      end
      ST_PM_REQ: begin
        if (pmReqReady) begin
          strobes.commitPm = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_IP_REQ: begin
        if (memReqReady) stateNext = ST_IP_WAIT;
      end
      ST_IP_WAIT: begin
        if (memRspValid) begin
          if (memRspAbort) begin
            strobes.commitAbort = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobes.captureIp = 1'b1;
            stateNext = ST_CS_REQ;
          end
        end
      end
      ST_CS_REQ: begin
        strobes.selCsAddr = 1'b1;
        if (memReqReady) stateNext = ST_CS_WAIT;
      end
      ST_CS_WAIT: begin
        strobes.selCsAddr = 1'b1;
        if (memRspValid) begin
          if (memRspAbort) strobes.commitAbort = 1'b1;
          else             strobes.commitOk    = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_IP_REQ) || (state == ST_CS_REQ);
  assign pmReqValid  = (state == ST_PM_REQ);

  // R1: the handoff path and the stack path never run together
  p_one_port_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && pmReqValid));

  // R9: an unaccepted read request stays raised
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

  // R1: an unacknowledged handoff stays raised
  p_pm_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pmReqValid && !pmReqReady) |=> pmReqValid);

endmodule

// File: rtl/farRetDatapath.sv
`timescale 1ns/1ps
module farRetDatapath
  import farRetPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 16,
  parameter int SEL_W      = 16,
  parameter int LANE_W     = 16,
  parameter int COST_LATER = 13,
  parameter int COST_EARLY = 18,
  parameter int COST_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              memReqValid,
  input  logic              opSize32,
  input  logic              stackSize32,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immCount,
  input  logic              laterModel,
  input  logic [ADDR_W-1:0] curIp,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  output logic              pmReqOpSize32,
  output logic [IMM_W-1:0]  pmReqImm,
  output logic [ADDR_W-1:0] newIp,
  output logic [SEL_W-1:0]  newCs,
  output logic [ADDR_W-1:0] newSp,
  output logic [COST_W-1:0] cycleCost,
  output logic [ADDR_W-1:0] savedIp,
  output logic              done,
  output logic              aborted
);

  localparam int UPPER_W  = ADDR_W - LANE_W;
  localparam int NARROW_B = 2;   // bytes per 16-bit stack item
  localparam int WIDE_B   = 4;   // bytes per 32-bit stack item

  logic              opSize32L;
  logic              stack32L;
  logic              laterL;
  logic [IMM_W-1:0]  immL;
  logic [ADDR_W-1:0] spL;
  logic [ADDR_W-1:0] ipTmp;

  logic [ADDR_W-1:0] csOffset;
  logic [ADDR_W-1:0] popBytes;
  logic [ADDR_W-1:0] ipAddr;
  logic [ADDR_W-1:0] csAddr;
  logic [ADDR_W-1:0] spNext;
  logic [LANE_W-1:0] laneCsAddr;
  logic [LANE_W-1:0] laneSpNext;
  logic [ADDR_W-1:0] rspNarrow;

  // captured operation context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opSize32L <= 1'b0;
      stack32L  <= 1'b0;
      laterL    <= 1'b0;
      immL      <= '0;
      spL       <= '0;
      savedIp   <= '0;
      ipTmp     <= '0;
    end else begin
      if (strobes.latchIn) begin
        opSize32L <= opSize32;
        stack32L  <= stackSize32;
        laterL    <= laterModel;
        immL      <= useImm ? immCount : '0;
        spL       <= curSp;
        savedIp   <= curIp;
      end
      if (strobes.captureIp) begin
        ipTmp <= opSize32L ? memRspData : rspNarrow;
      end
    end
  end

  assign rspNarrow = {{UPPER_W{1'b0}}, memRspData[LANE_W-1:0]};

  // address and pointer arithmetic
  assign csOffset   = opSize32L ? ADDR_W'(WIDE_B) : ADDR_W'(NARROW_B);
  assign popBytes   = ADDR_W'(2 * (opSize32L ? WIDE_B : NARROW_B)) + ADDR_W'(immL);
  assign laneCsAddr = spL[LANE_W-1:0] + csOffset[LANE_W-1:0];
  assign laneSpNext = spL[LANE_W-1:0] + popBytes[LANE_W-1:0];

  always_comb begin
    if (stack32L) begin
      ipAddr = spL;
      csAddr = spL + csOffset;
      spNext = spL + popBytes;
    end else begin
      ipAddr = {{UPPER_W{1'b0}}, spL[LANE_W-1:0]};
      csAddr = {{UPPER_W{1'b0}}, laneCsAddr};
      spNext = {spL[ADDR_W-1:LANE_W], laneSpNext};
    end
  end

  assign memAddr       = strobes.selCsAddr ? csAddr : ipAddr;
  assign memWide       = opSize32L;
  assign pmReqOpSize32 = opSize32L;
  assign pmReqImm      = immL;

  // commit stage: results change only here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newIp     <= '0;
      newCs     <= '0;
      newSp     <= '0;
      cycleCost <= '0;
      done      <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      done    <= strobes.commitOk | strobes.commitAbort | strobes.commitPm;
      aborted <= strobes.commitAbort;
      if (strobes.commitOk) begin
        newIp     <= ipTmp;
        newCs     <= memRspData[SEL_W-1:0];
        newSp     <= spNext;
        cycleCost <= laterL ? COST_W'(COST_LATER) : COST_W'(COST_EARLY);
      end else if (strobes.commitAbort) begin
        newIp     <= savedIp;
        newSp     <= spL;
        cycleCost <= '0;
      end else if (strobes.commitPm) begin
        cycleCost <= '0;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: an aborted return carries no cost
  p_abort_cost_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && aborted) |-> (cycleCost == '0));

  // R8: any charged cost is one of the two model values
  p_cost_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && cycleCost != '0) |->
      (cycleCost == COST_W'(COST_LATER) || cycleCost == COST_W'(COST_EARLY)));

  // R7: narrow-stack requests stay inside the low 64 KiB
  p_narrow_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !stack32L) |-> (memAddr[ADDR_W-1:LANE_W] == '0));

endmodule

// File: rtl/farRetSeq.sv
`timescale 1ns/1ps
module farRetSeq
  import farRetPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 16,
  parameter int SEL_W      = 16,
  parameter int COST_LATER = 13,
  parameter int COST_EARLY = 18,
  localparam int COST_MAX  = (COST_LATER > COST_EARLY) ? COST_LATER : COST_EARLY,
  localparam int COST_W    = $clog2(COST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSize32,
  input  logic              stackSize32,
  input  logic              useImm,
  input  logic [IMM_W-1:0]  immCount,
  input  logic              protEnable,
  input  logic              v86Mode,
  input  logic              laterModel,
  input  logic [ADDR_W-1:0] curIp,
  input  logic [ADDR_W-1:0] curSp,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWide,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              memRspAbort,
  output logic              pmReqValid,
  input  logic              pmReqReady,
  output logic              pmReqOpSize32,
  output logic [IMM_W-1:0]  pmReqImm,
  output logic [ADDR_W-1:0] newIp,
  output logic [SEL_W-1:0]  newCs,
  output logic [ADDR_W-1:0] newSp,
  output logic [COST_W-1:0] cycleCost,
  output logic [ADDR_W-1:0] savedIp,
  output logic              done,
  output logic              aborted
);

  localparam int LANE_W = 16;

  ctrlStrobes_t strobes;

  farRetCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .protEnable  (protEnable),
    .v86Mode     (v86Mode),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspAbort (memRspAbort),
    .pmReqReady  (pmReqReady),
    .memReqValid (memReqValid),
    .pmReqValid  (pmReqValid),
    .strobes     (strobes)
  );

  farRetDatapath #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .SEL_W      (SEL_W),
    .LANE_W     (LANE_W),
    .COST_LATER (COST_LATER),
    .COST_EARLY (COST_EARLY),
    .COST_W     (COST_W)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .memReqValid   (memReqValid),
    .opSize32      (opSize32),
    .stackSize32   (stackSize32),
    .useImm        (useImm),
    .immCount      (immCount),
    .laterModel    (laterModel),
    .curIp         (curIp),
    .curSp         (curSp),
    .memRspData    (memRspData),
    .memAddr       (memAddr),
    .memWide       (memWide),
    .pmReqOpSize32 (pmReqOpSize32),
    .pmReqImm      (pmReqImm),
    .newIp         (newIp),
    .newCs         (newCs),
    .newSp         (newSp),
    .cycleCost     (cycleCost),
    .savedIp       (savedIp),
    .done          (done),
    .aborted       (aborted)
  );

  // R9: a pending read keeps its address and width
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> ($stable(memAddr) && $stable(memWide)));

  // R1: a pending handoff keeps its payload
  p_pm_payload_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pmReqValid && !pmReqReady) |=> ($stable(pmReqImm) && $stable(pmReqOpSize32)));

endmodule

// File: tb/tb_farRetSeq.sv
`timescale 1ns/1ps
module tb_farRetSeq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        opSize32, stackSize32, useImm, protEnable, v86Mode, laterModel;
  logic [15:0] immCount;
  logic [31:0] curIp, curSp;
  logic        memReqValid, memReqReady, memWide, memRspValid, memRspAbort;
  logic [31:0] memAddr, memRspData;
  logic        pmReqValid, pmReqReady, pmReqOpSize32;
  logic [15:0] pmReqImm;
  logic [31:0] newIp, newSp, savedIp;
  logic [15:0] newCs;
  logic [4:0]  cycleCost;
  logic        done, aborted;

  always #4 clk = ~clk;

  farRetSeq dut (
    .clk(clk), .rstN(rstN), .start(start), .opSize32(opSize32),
    .stackSize32(stackSize32), .useImm(useImm), .immCount(immCount),
    .protEnable(protEnable), .v86Mode(v86Mode), .laterModel(laterModel),
    .curIp(curIp), .curSp(curSp),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memWide(memWide), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspAbort(memRspAbort),
    .pmReqValid(pmReqValid), .pmReqReady(pmReqReady),
    .pmReqOpSize32(pmReqOpSize32), .pmReqImm(pmReqImm),
    .newIp(newIp), .newCs(newCs), .newSp(newSp), .cycleCost(cycleCost),
    .savedIp(savedIp), .done(done), .aborted(aborted)
  );

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  // reference model state
  logic [31:0] expQ[$];
  bit          expWide;
  bit          expPm;
  bit          expPmOp;
  logic [15:0] expPmImm;
  int          abortIdx;
  int          readIdx;
  bit          awaiting;
  logic [31:0] expIp, expSp;
  logic [15:0] expCs;

  function automatic logic [31:0] memData(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C ^ a[31:16], a[15:0] ^ 16'hC0DE ^ {a[7:0], a[15:8]}};
  endfunction

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: random accept delay, random response delay
  initial begin
    logic [31:0] pendAddr;
    bit          pending;
    int          delay;
    memReqReady = 0; memRspValid = 0; memRspAbort = 0; memRspData = '0;
    pending = 0; delay = 0; pendAddr = '0;
    forever begin
      @(negedge clk);
      memReqReady = 0; memRspValid = 0; memRspAbort = 0;
      if (done && !awaiting) checkEq("R10", "unexpected done", 32'(done), 32'd0);
      if (pending) begin
        if (delay == 0) begin
          memRspValid = 1;
          memRspData  = memData(pendAddr);
          memRspAbort = (readIdx == abortIdx);
          readIdx++;
          pending = 0;
        end else delay--;
      end else if (memReqValid) begin
        if (expQ.size() == 0) begin
          checkEq("R9", "unexpected read", memAddr, 32'hFFFF_FFFF);
        end else if (($urandom % 3) != 0) begin
          pendAddr = expQ.pop_front();
          checkEq("R9", "read address", memAddr, pendAddr);
          checkEq(expWide ? "R3" : "R2", "read width", 32'(memWide), 32'(expWide));
          memReqReady = 1;
          pending = 1;
          delay = $urandom % 3;
        end
      end
    end
  end

  // protected-mode handler model
  initial begin
    bit seen;
    seen = 0;
    pmReqReady = 0;
    forever begin
      @(negedge clk);
      pmReqReady = 0;
      if (pmReqValid) begin
        if (!seen) begin
          checkEq("R1", "handoff expected", 32'(expPm), 32'd1);
          checkEq("R1", "handoff op size", 32'(pmReqOpSize32), 32'(expPmOp));
          checkEq("R5", "handoff count", 32'(pmReqImm), 32'(expPmImm));
          seen = 1;
        end
        if (($urandom % 2) != 0) begin
          pmReqReady = 1;
          seen = 0;
        end
      end
    end
  end

  task automatic runRet(input bit pe, input bit v86, input bit op32, input bit s32,
                        input bit ui, input logic [15:0] imm, input logic [31:0] sp,
                        input logic [31:0] ip, input bit later, input int abortAt,
                        input bit poke);
    logic [31:0] base, csA, inc, nsp, ipE;
    logic [15:0] immE, csE;
    bit pm;
    int cyc;
    pm   = pe && !v86;
    immE = ui ? imm : 16'h0;
    base = s32 ? sp : {16'h0, sp[15:0]};
    csA  = s32 ? sp + (op32 ? 32'd4 : 32'd2)
               : {16'h0, sp[15:0] + (op32 ? 16'd4 : 16'd2)};
    inc  = (op32 ? 32'd8 : 32'd4) + 32'(immE);
    nsp  = s32 ? sp + inc : {sp[31:16], sp[15:0] + inc[15:0]};
    expQ.delete();
    readIdx = 0; abortIdx = abortAt; expWide = op32;
    expPm = pm; expPmOp = op32; expPmImm = immE;
    if (!pm) begin
      expQ.push_back(base);
      if (abortAt != 0) expQ.push_back(csA);
    end
    awaiting = 1;
    @(negedge clk);
    protEnable = pe; v86Mode = v86; opSize32 = op32; stackSize32 = s32;
    useImm = ui; immCount = imm; curSp = sp; curIp = ip; laterModel = later;
    start = 1;
    @(negedge clk);
    start = 0;
    // R12: inputs after start must not matter
    curIp = ~ip; curSp = ~sp; opSize32 = ~op32; stackSize32 = ~s32;
    immCount = ~imm; useImm = ~ui; laterModel = ~later;
    if (poke) begin
      @(negedge clk);
      start = 1; protEnable = 1; v86Mode = 0;
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    checkEq("R10", "done seen", 32'(done), 32'd1);
    checkEq("R11", "savedIp", savedIp, ip);
    if (pm) begin
      checkEq("R1", "aborted", 32'(aborted), 32'd0);
      checkEq("R1", "cost", 32'(cycleCost), 32'd0);
      checkEq("R1", "ip held", newIp, expIp);
      checkEq("R1", "cs held", 32'(newCs), 32'(expCs));
      checkEq("R1", "sp held", newSp, expSp);
    end else if (abortAt >= 0) begin
      checkEq("R6", "aborted", 32'(aborted), 32'd1);
      checkEq("R6", "cost", 32'(cycleCost), 32'd0);
      checkEq("R6", "ip restored", newIp, ip);
      checkEq("R6", "sp kept", newSp, sp);
      checkEq("R6", "cs kept", 32'(newCs), 32'(expCs));
      expIp = ip; expSp = sp;
    end else begin
      ipE = op32 ? memData(base) : {16'h0, memData(base)[15:0]};
      csE = memData(csA)[15:0];
      checkEq("R8", "aborted", 32'(aborted), 32'd0);
      checkEq(op32 ? "R3" : "R2", "newIp", newIp, ipE);
      checkEq(op32 ? "R3" : "R2", "newCs", 32'(newCs), 32'(csE));
      checkEq(s32 ? "R4" : "R7", "newSp", newSp, nsp);
      checkEq("R8", "cost", 32'(cycleCost), later ? 32'd13 : 32'd18);
      expIp = ipE; expCs = csE; expSp = nsp;
    end
    checkEq("R9", "reads left", 32'(expQ.size()), 32'd0);
    @(negedge clk);
    checkEq("R10", "done pulse width", 32'(done), 32'd0);
    checkEq("R10", "ip still held", newIp, expIp);
    awaiting = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; start = 0; opSize32 = 0; stackSize32 = 0; useImm = 0; immCount = '0;
    protEnable = 0; v86Mode = 0; laterModel = 0; curIp = '0; curSp = '0;
    awaiting = 0; expIp = '0; expCs = '0; expSp = '0;
    abortIdx = -1; readIdx = 0; expWide = 0; expPm = 0; expPmOp = 0; expPmImm = '0;
    repeat (3) @(negedge clk);
    checkEq("R10", "reset done", 32'(done), 32'd0);
    checkEq("R9", "reset memReqValid", 32'(memReqValid), 32'd0);
    checkEq("R1", "reset pmReqValid", 32'(pmReqValid), 32'd0);
    checkEq("R2", "reset newIp", newIp, 32'd0);
    checkEq("R4", "reset newSp", newSp, 32'd0);
    rstN = 1;
    @(negedge clk);
    // R2 16-bit operands, 16-bit stack, later model
    runRet(0, 0, 0, 0, 0, 16'h0000, 32'hABCD_0100, 32'h0000_1234, 1, -1, 0);
    // R3 R4 32-bit operands, 32-bit stack, release count, earlier model
    runRet(0, 0, 1, 1, 1, 16'h0010, 32'h0012_FFF0, 32'h0040_0000, 0, -1, 0);
    // R7 narrow stack with wrap of the selector address and the pointer
    runRet(0, 0, 0, 0, 1, 16'h0006, 32'h1234_FFFE, 32'h0000_0010, 1, -1, 0);
    runRet(0, 0, 1, 0, 0, 16'h0000, 32'h5555_FFFC, 32'h0000_0020, 0, -1, 0);
    // R7 wide stack with carry into upper half
    runRet(0, 0, 0, 1, 1, 16'h0100, 32'h0001_FF00, 32'h0000_0030, 1, -1, 0);
    // R1 handoff, then R1 with v86 set runs the stack path
    runRet(1, 0, 1, 1, 1, 16'h0020, 32'h0000_8000, 32'h0000_0040, 1, -1, 0);
    runRet(1, 1, 0, 0, 0, 16'h0000, 32'h0000_0200, 32'h0000_0050, 0, -1, 0);
    // R5 ignored count with all ones, in both paths
    runRet(0, 0, 0, 0, 0, 16'hFFFF, 32'h0000_0300, 32'h0000_0060, 1, -1, 0);
    runRet(1, 0, 0, 0, 0, 16'hFFFF, 32'h0000_0300, 32'h0000_0070, 1, -1, 0);
    // R6 abort on the first and on the second read
    runRet(0, 0, 1, 1, 1, 16'h0004, 32'h0000_0400, 32'h0000_0080, 1, 0, 0);
    runRet(0, 0, 0, 0, 0, 16'h0000, 32'h7777_0500, 32'h0000_0090, 0, 1, 0);
    // R12 start pulsed while busy
    runRet(0, 0, 1, 0, 1, 16'h0002, 32'h0000_0600, 32'h0000_00A0, 1, -1, 1);
    for (int i = 0; i < 40; i++) begin
      runRet(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), $urandom, $urandom, 1'($urandom),
             (($urandom % 4) == 0) ? int'($urandom % 2) : -1, 1'($urandom));
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule